// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management interface of an Ethernet PHY. Software fills an address register (PHY address, register number and a read/write selector) and, for writes, a data register. It then sets the status bit of the control register to launch one management frame. The block produces the management clock by dividing the system clock and drives the data line as a separate value, output-enable and input. It shifts the frame out most significant bit first and releases the line for the read turnaround. It samples the returned word and clears the status bit when the last bit period ends.

Each frame is 64 bit periods long, in this order: 32 preamble ones, start `01`, op `10` for a read or `01` for a write, 5-bit PHY address, 5-bit register number, a 2-bit turnaround and 16 data bits. The block changes the data line on the falling edge of the management clock, and both the PHY and the master sample it on the rising edge. The management clock toggles every `MDC_HALF` system clocks, so one frame takes 128 × `MDC_HALF` system clocks.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: The address register (byte offset 0x7E4) reads back bits 10:0 as written: bits 4:0 hold the register number, bits 9:5 the PHY address and bit 10 the op (1 read, 0 write); bits 31:11 read 0. The write-data register (0x7E8) reads back bits 15:0 and reads 0 above them. The read-data register (0x7EC) ignores writes.
- R3: Control register (0x7F0) bit 3 is the enable and reads back as last written. Bit 0 reads 1 while a frame is in progress and 0 otherwise. All other control bits read 0.
- R4: A control write with bit 0 set and bit 3 clear starts nothing: the status bit stays 0 and `mdc` stays low.
- R5: A control write with bits 0 and 3 both set, made while idle, starts a frame. The values sampled on successive rising `mdc` edges are 32 ones, then 0,1, then the op code (1,0 read; 0,1 write), then the PHY address and the register number, each MSB first.
- R6: A write frame keeps `mdio_oe` high for all 64 bit periods and sends turnaround 1,0 followed by the 16 write-data bits, MSB first.
- R7: A read frame drives the first 46 bit periods and holds `mdio_oe` low for the last 18. It samples `mdio_i` at the last 16 rising edges, MSB first. When the frame ends, the read-data register holds that word in bits 15:0.
- R8: While a frame runs, `mdc` toggles every `MDC_HALF` system clocks, starting low and going high `MDC_HALF` clocks after the launch. While idle, `mdc` is low and `mdio_oe` is low.
- R9: The status bit clears exactly 128 × `MDC_HALF` clocks after the launching write. A start request, or a change to the address or write-data registers, made while busy has no effect on the frame in progress or on its length.
- R10: `mdio_o` changes only on the clock where `mdc` falls or when a frame is launched, never while `mdc` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data value driven by the master |
| mdio_oe | output | 1 | Output enable of the management data line |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
A corrupted divider count or bit index shows at once at the ports. `mdc` toggles on the wrong clock, or `mdio_oe` falls in the wrong bit period, and the per-clock model flags that clock. A stale busy or op flag shows as a status bit that clears early or late, or as a read frame that keeps driving the turnaround; both are caught within one bit period. Shifter or capture errors show only when the frame is complete: the PHY model compares the 64 sampled bits, and the read-data register is checked on the clock the frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
    localparam int DATA_POS   = FRAME_BITS - DATA_W;
    localparam int ADR_W      = PHY_W + REG_W + 1;

    localparam logic [11:0] OFF_ADR  = 12'h7E4;
    localparam logic [11:0] OFF_WDAT = 12'h7E8;
    localparam logic [11:0] OFF_RDAT = 12'h7EC;
    localparam logic [11:0] OFF_CTRL = 12'h7F0;

    localparam int CTRL_GO = 0;
    localparam int CTRL_EN = 3;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(MDC_HALF + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } clk_t;

    clk_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = run && (q.cnt == CW'(MDC_HALF - 1));
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc  = q.mdc;
    assign rise = wrap && !q.mdc;
    assign fall = wrap && q.mdc;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_op_e          op,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regn,
    input  logic [DATA_W-1:0] wdat,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] cap,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [FRAME_BITS-1:0] sh;
        logic [IDX_W-1:0]      idx;
        logic [DATA_W-1:0]     cap;
    } eng_t;

    eng_t q, d;
    logic last;
    logic is_rd;

    assign is_rd = (op == OP_READ);

    always_comb begin
        d    = q;
        last = q.busy && fall && (q.idx == IDX_W'(FRAME_BITS - 1));
        if (start) begin
            d.busy = 1'b1;
            d.rd   = is_rd;
            d.idx  = '0;
            d.cap  = '0;
            d.sh   = {{PRE_BITS{1'b1}}, 2'b01,
                      is_rd ? 2'b10 : 2'b01, phy, regn,
                      is_rd ? 2'b11 : 2'b10,
                      is_rd ? {DATA_W{1'b1}} : wdat};
        end else if (q.busy) begin
            if (rise && q.rd && (q.idx >= IDX_W'(DATA_POS)))
                d.cap = {q.cap[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (last) begin
                    d.busy = 1'b0;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                    d.sh  = {q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign rd_done = last && q.rd;
    assign cap     = q.cap;
    assign mdio_o  = q.busy ? q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = q.busy && (!q.rd || (q.idx < IDX_W'(TA_POS)));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] cap,
    output logic              start,
    output mdio_op_e          op,
    output logic [PHY_W-1:0]  phy,
    output logic [REG_W-1:0]  regn,
    output logic [DATA_W-1:0] wdat
);
    localparam logic [AW-1:0] A_ADR  = AW'(OFF_ADR);
    localparam logic [AW-1:0] A_WDAT = AW'(OFF_WDAT);
    localparam logic [AW-1:0] A_RDAT = AW'(OFF_RDAT);
    localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);

    typedef struct packed {
        logic [ADR_W-1:0]  adr;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        logic              en;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        if (wr) begin
            if (addr == A_ADR)  d.adr = wdata[ADR_W-1:0];
            if (addr == A_WDAT) d.wd  = wdata[DATA_W-1:0];
            if (addr == A_CTRL) begin
                d.en  = wdata[CTRL_EN];
                start = wdata[CTRL_GO] && wdata[CTRL_EN] && !busy;
            end
        end
        if (rd_done) d.rd = cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_ADR)  rdata[ADR_W-1:0]  = q.adr;
        if (addr == A_WDAT) rdata[DATA_W-1:0] = q.wd;
        if (addr == A_RDAT) rdata[DATA_W-1:0] = q.rd;
        if (addr == A_CTRL) begin
            rdata[CTRL_EN] = q.en;
            rdata[CTRL_GO] = busy;
        end
    end

    assign op   = mdio_op_e'(q.adr[ADR_W-1]);
    assign phy  = q.adr[REG_W +: PHY_W];
    assign regn = q.adr[REG_W-1:0];
    assign wdat = q.wd;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 50,
    parameter int AW       = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    logic              start;
    mdio_op_e          op;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regn;
    logic [DATA_W-1:0] wdat;
    logic [DATA_W-1:0] cap;
    logic              eng_busy;
    logic              rd_done;
    logic              rise;
    logic              fall;

    mdio_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy),
        .rd_done(rd_done), .cap(cap), .start(start), .op(op),
        .phy(phy), .regn(regn), .wdat(wdat)
    );

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(eng_busy),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .phy(phy),
        .regn(regn), .wdat(wdat), .rise(rise), .fall(fall),
        .mdio_i(mdio_i), .busy(eng_busy), .rd_done(rd_done), .cap(cap),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int MDC_HALF = 50,
    parameter int AW       = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mdc,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata
);
    localparam logic [AW-1:0] A_CTRL = AW'(12'h7F0);

    logic        mdc_prev;
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            mdc_prev <= mdc;
            if (!busy)                run_len <= '0;
            else if (mdc != mdc_prev) run_len <= 16'd1;
            else                      run_len <= run_len + 16'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R8

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mdc != mdc_prev)) |-> (run_len == 16'(MDC_HALF))); // R8

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o)); // R10

    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0] && !reg_wdata[3] && !busy)
        |=> !busy); // R4

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0] && reg_wdata[3] && !busy)
        |=> (busy && !mdc)); // R5
endmodule

bind mdio_master mdio_master_chk #(.MDC_HALF(MDC_HALF), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int H    = 50;
    localparam int AW   = 12;
    localparam int FLEN = 128 * H;
    localparam logic [11:0] A_ADR  = 12'h7E4;
    localparam logic [11:0] A_WD   = 12'h7E8;
    localparam logic [11:0] A_RD   = 12'h7EC;
    localparam logic [11:0] A_CTRL = 12'h7F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = A_CTRL;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    mdio_master #(.MDC_HALF(H), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model of registers and timing
    logic [10:0] m_adr;
    logic [15:0] m_wd, m_rd;
    logic        m_en, m_read;
    int          mcnt;
    logic [15:0] phy_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_adr <= '0; m_wd <= '0; m_rd <= '0; m_en <= 1'b0;
            m_read <= 1'b0; mcnt <= 0;
        end else begin
            if (mcnt == 1 && m_read) m_rd <= phy_val;
            if (mcnt > 0) mcnt <= mcnt - 1;
            if (reg_wr) begin
                if (reg_addr == A_ADR) m_adr <= reg_wdata[10:0];
                if (reg_addr == A_WD)  m_wd  <= reg_wdata[15:0];
                if (reg_addr == A_CTRL) begin
                    m_en <= reg_wdata[3];
                    if (reg_wdata[0] && reg_wdata[3] && mcnt == 0) begin
                        mcnt   <= FLEN;
                        m_read <= m_adr[10];
                    end
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(logic [AW-1:0] a);
        if (a == A_ADR)  return {21'b0, m_adr};
        if (a == A_WD)   return {16'b0, m_wd};
        if (a == A_RD)   return {16'b0, m_rd};
        if (a == A_CTRL) return {28'b0, m_en, 2'b0, logic'(mcnt != 0)};
        return 32'b0;
    endfunction

    logic prev_mdc = 1'b0, prev_o = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            int  k;
            logic e_mdc, e_oe;
            k     = FLEN - mcnt;
            e_mdc = (mcnt != 0) && (((k / H) % 2) == 1);
            e_oe  = (mcnt != 0) && (!m_read || (k / (2 * H)) < 46);
            check("R8 mdc per clock", {31'b0, mdc}, {31'b0, e_mdc});
            check("R6/R7 mdio_oe per clock", {31'b0, mdio_oe}, {31'b0, e_oe});
            check("R3/R9 register read per clock", reg_rdata, model_rd(reg_addr));
            if (mdc && prev_mdc)
                check("R10 mdio_o stable while mdc high", {31'b0, mdio_o}, {31'b0, prev_o});
            prev_mdc = mdc;
            prev_o   = mdio_o;
        end
    end

    // simple PHY model
    logic [63:0] bits, oes;
    int idx = 0;
    always @(posedge mdc) begin
        #1;
        if (idx < 64) begin
            bits[63 - idx] = mdio_o;
            oes[63 - idx]  = mdio_oe;
        end
        idx++;
    end
    always @(negedge mdc) begin
        #1;
        if (idx >= 48 && idx <= 63) mdio_i = phy_val[63 - idx];
        else                        mdio_i = 1'b1;
    end

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = A_CTRL; reg_wdata = '0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, exp);
        #1 reg_addr = A_CTRL;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (mcnt != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(bit rd, logic [4:0] phy, logic [4:0] rg,
                        logic [15:0] wd, logic [15:0] rv, bit disturb);
        logic [63:0] hdr;
        phy_val = rv;
        wr(A_ADR, {21'b0, rd, phy, rg});
        wr(A_WD, {16'b0, wd});
        idx = 0;
        wr(A_CTRL, 32'h9);
        if (disturb) begin
            repeat (1000) @(posedge clk);
            wr(A_CTRL, 32'h9);
            wr(A_ADR, {21'b0, ~rd, ~phy, ~rg});
            wr(A_WD, {16'b0, ~wd});
        end
        wait_idle();
        check("R9 bit periods per frame", idx, 64);
        hdr = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 18'b0};
        check("R5 frame header hi", bits[63:32], hdr[63:32]);
        check("R5 frame header lo", {18'b0, bits[31:18]}, {18'b0, hdr[31:18]});
        if (!rd) begin
            check("R6 turnaround and data", {14'b0, bits[17:0]}, {14'b0, 2'b10, wd});
            check("R6 oe all periods", oes[31:0] & oes[63:32], 32'hFFFF_FFFF);
        end else begin
            check("R7 oe pattern", {oes[63:32]}, 32'hFFFF_FFFF);
            check("R7 oe pattern lo", {14'b0, oes[17:0]}, 32'h0);
            check("R7 oe header lo", {18'b0, oes[31:18]}, {18'b0, 14'h3FFF});
            rd_chk(A_RD, {16'b0, rv}, "R7 read data register");
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        phy_val = 16'h0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 mdc after reset", {31'b0, mdc}, 32'h0);
        check("R1 oe after reset", {31'b0, mdio_oe}, 32'h0);
        rd_chk(A_ADR,  32'h0, "R1 address reg reset");
        rd_chk(A_WD,   32'h0, "R1 write data reset");
        rd_chk(A_RD,   32'h0, "R1 read data reset");
        rd_chk(A_CTRL, 32'h0, "R1 control reset");

        wr(A_ADR, 32'hFFFF_FFFF);
        rd_chk(A_ADR, 32'h0000_07FF, "R2 address reg width");
        wr(A_WD, 32'hFFFF_FFFF);
        rd_chk(A_WD, 32'h0000_FFFF, "R2 write data width");
        wr(A_RD, 32'hFFFF_FFFF);
        rd_chk(A_RD, 32'h0, "R2 read data ignores writes");

        wr(A_CTRL, 32'h8);
        rd_chk(A_CTRL, 32'h8, "R3 enable reads back");
        wr(A_CTRL, 32'h0);
        rd_chk(A_CTRL, 32'h0, "R3 enable cleared");

        idx = 0;
        wr(A_CTRL, 32'h1);
        repeat (300) @(negedge clk);
        rd_chk(A_CTRL, 32'h0, "R4 start ignored when disabled");
        check("R4 no mdc edges", idx, 0);

        xfer(1'b0, 5'h15, 5'h0A, 16'hA5C3, 16'h0, 1'b0);
        xfer(1'b1, 5'h01, 5'h02, 16'h0, 16'h1234, 1'b0);
        xfer(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h8001, 1'b0);
        xfer(1'b0, 5'h00, 5'h11, 16'h0F0F, 16'h0, 1'b1);
        xfer(1'b1, 5'h0A, 5'h05, 16'h0, 16'hFFFE, 1'b1);
        rd_chk(A_CTRL, 32'h8, "R9 idle after frames");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule